// File: doc/BRIEF.md
# Alternate-Phase Dual DAC Front-End

This block is the digital side of a two-channel 10-bit converter in which both channels share one parallel data bus. The bus is split between the channels by clock phase. Channel 1 samples it on the rising clock edge and channel 2 on the falling edge. Each channel passes its word through a capture latch and then a converter register, and the register drives that channel's current-switch array. The two output codes therefore never change on the same edge.

A small power controller takes a power-down select pin and an enable pin and chooses one of three modes: shutdown, standby or active. The per-channel drive flags (low means the analog output floats) are high only in active mode. The converter registers keep their last code through standby and shutdown, so the outputs return to that code on wake-up. A wake-up counter holds a ready flag low for a programmable number of cycles after each entry into active mode.

Top module: `apdac_frontend`

## Requirements
- R1: While `rst` is high at rising edges, both codes become 0, `pwrMode` becomes shutdown (2'b00), and `outEn1`, `outEn2` and `ready` are low.
- R2: At each rising edge `pwrMode` takes the value the pins select. With `pdSel` high it is shutdown (2'b00), whatever `dacEn` is. With `pdSel` low it is standby (2'b01) when `dacEn` is low and active (2'b10) when `dacEn` is high.
- R3: In active mode with `csN` low, channel 1 captures `dataBus` at a rising edge, and bus bit i lands in code bit i. The word reaches `code1` at the next rising edge.
- R4: In active mode with `csN` low, channel 2 captures `dataBus` at a falling edge. The word reaches `code2` at the next falling edge.
- R5: `code1` changes only at rising edges and `code2` only at falling edges.
- R6: When `csN` is high at an edge, that channel ignores the bus, and its code settles on the last word it captured.
- R7: Outside active mode, both channels ignore the bus and both codes hold their value. On the return to active mode, the codes still show the values held before standby or shutdown.
- R8: `outEn1` and `outEn2` are high in active mode and low (output released) in standby and in shutdown.
- R9: `ready` is low outside active mode. On entry to active mode it stays low and rises exactly WAKE_CYCLES rising edges after the edge that entered active mode. It then stays high while the block remains active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge serves channel 1 and the controller, falling edge serves channel 2 |
| rst | input | 1 | Synchronous reset, active high |
| dataBus | input | 10 | Shared data word, bit 0 least significant |
| csN | input | 1 | Chip select, active low, sampled at each capturing edge |
| dacEn | input | 1 | Enable: high selects active, low selects standby (when pdSel is low) |
| pdSel | input | 1 | Power-down select: high forces shutdown |
| code1 | output | 10 | Channel 1 converter register |
| code2 | output | 10 | Channel 2 converter register |
| outEn1 | output | 1 | Channel 1 output drive enable (low = released) |
| outEn2 | output | 1 | Channel 2 output drive enable (low = released) |
| pwrMode | output | 2 | Power mode: 00 shutdown, 01 standby, 10 active |
| ready | output | 1 | Outputs settled after wake-up |

## Verification
The in-line properties check, every cycle, that the mode follows the pins one edge later. They also check that each capture latch takes the bus word when it is selected and enabled, that a disabled channel's register stays put, and that `ready` never rises on the edge that enters active mode and never drops while the block stays active. The exact latency of each channel, the phase separation between the two codes, the precise wake-up count and the retention of codes across standby and shutdown can only be shown by the bench's directed scenarios, which compare the port values against an independent model.

// File: rtl/apdac_pkg.sv
`timescale 1ns/1ps
package apdac_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    PWR_SHUT   = 2'b00,
    PWR_STBY   = 2'b01,
    PWR_ACTIVE = 2'b10
  } pwrMode_e;

  // strobes from the power controller to the channel datapath
  typedef struct packed {
    logic runEn;   // capture and shift allowed, outputs driven
  } dpStrobe_t;

endpackage

// File: rtl/apdac_ctrl.sv
`timescale 1ns/1ps
module apdac_ctrl
  import apdac_pkg::*;
#(
  parameter int WAKE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pdSel,
  input  logic       dacEn,
  output pwrMode_e   modeOut,
  output logic       ready,
  output dpStrobe_t  strb
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 2);
  localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYCLES);

  pwrMode_e         modeQ;
  pwrMode_e         modeNext;
  logic [CNT_W-1:0] wakeCnt;
  logic             enterActive;

  // pin decode: power-down select dominates the enable
  always_comb begin
    if (pdSel)      modeNext = PWR_SHUT;
    else if (dacEn) modeNext = PWR_ACTIVE;
    else            modeNext = PWR_STBY;
  end

  assign enterActive = (modeNext == PWR_ACTIVE) && (modeQ != PWR_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ   <= PWR_SHUT;
      wakeCnt <= '0;
    end else begin
      modeQ <= modeNext;
      if (enterActive) begin
        wakeCnt <= WAKE_LOAD;
      end else if ((modeQ == PWR_ACTIVE) && (wakeCnt != '0)) begin
        wakeCnt <= wakeCnt - 1'b1;
      end
    end
  end

  assign modeOut    = modeQ;
  assign ready      = (modeQ == PWR_ACTIVE) && (wakeCnt == '0);
  assign strb.runEn = (modeQ == PWR_ACTIVE);

  AST_PD_FORCES_SHUT: assert property (@(posedge clk) disable iff (rst)
    (pdSel) |=> (modeOut == PWR_SHUT)); // R2

  AST_STBY_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!pdSel && !dacEn) |=> (modeOut == PWR_STBY)); // R2

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ready && !pdSel && dacEn) |=> ready); // R9

  generate
    if (WAKE_CYCLES > 0) begin : g_wakeChk
      AST_WAKE_GAP: assert property (@(posedge clk) disable iff (rst)
        ((modeOut != PWR_ACTIVE) && !pdSel && dacEn) |=> !ready); // R9
    end
  endgenerate

endmodule

// File: rtl/apdac_datapath.sv
`timescale 1ns/1ps
module apdac_datapath
  import apdac_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           csN,
  input  logic [DATA_W-1:0]              dataBus,
  input  dpStrobe_t                      strb,
  output logic [NUM_CH-1:0][DATA_W-1:0]  codeOut,
  output logic [NUM_CH-1:0]              driveEn
);

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DATA_W-1:0] inLatch;
      logic [DATA_W-1:0] dacReg;

      if ((ch % 2) == 0) begin : g_rise
        // even channel: rising-edge capture and shift
        always_ff @(posedge clk) begin
          if (rst) begin
            inLatch <= '0;
            dacReg  <= '0;
          end else if (strb.runEn) begin
            if (!csN) inLatch <= dataBus;
            dacReg <= inLatch;
          end
        end

        AST_CAPTURE_RISE: assert property (@(posedge clk) disable iff (rst)
          (strb.runEn && !csN) |=> (inLatch == $past(dataBus))); // R3

        AST_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
          (!strb.runEn) |=> $stable(dacReg)); // R7
      end else begin : g_fall
        // odd channel: falling-edge capture and shift
        always_ff @(negedge clk) begin
          if (rst) begin
            inLatch <= '0;
            dacReg  <= '0;
          end else if (strb.runEn) begin
            if (!csN) inLatch <= dataBus;
            dacReg <= inLatch;
          end
        end

        AST_CAPTURE_FALL: assert property (@(negedge clk) disable iff (rst)
          (strb.runEn && !csN) |=> (inLatch == $past(dataBus))); // R4

        AST_HOLD_FALL: assert property (@(negedge clk) disable iff (rst)
          (!strb.runEn) |=> $stable(dacReg)); // R7
      end

      assign codeOut[ch] = dacReg;
      assign driveEn[ch] = strb.runEn;
    end
  endgenerate

endmodule

// File: rtl/apdac_frontend.sv
`timescale 1ns/1ps
module apdac_frontend
  import apdac_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int WAKE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              csN,
  input  logic              dacEn,
  input  logic              pdSel,
  output logic [DATA_W-1:0] code1,
  output logic [DATA_W-1:0] code2,
  output logic              outEn1,
  output logic              outEn2,
  output logic [1:0]        pwrMode,
  output logic              ready
);

  pwrMode_e                       modeW;
  dpStrobe_t                      strbW;
  logic [NUM_CH-1:0][DATA_W-1:0]  codeW;
  logic [NUM_CH-1:0]              drvW;

  apdac_ctrl #(
    .WAKE_CYCLES (WAKE_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .pdSel   (pdSel),
    .dacEn   (dacEn),
    .modeOut (modeW),
    .ready   (ready),
    .strb    (strbW)
  );

  apdac_datapath #(
    .DATA_W (DATA_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .csN     (csN),
    .dataBus (dataBus),
    .strb    (strbW),
    .codeOut (codeW),
    .driveEn (drvW)
  );

  assign code1   = codeW[0];
  assign code2   = codeW[1];
  assign outEn1  = drvW[0];
  assign outEn2  = drvW[1];
  assign pwrMode = modeW;

endmodule

// File: tb/apdac_frontend_tb_top.sv
`timescale 1ns/1ps
module apdac_frontend_tb_top;

  localparam int WAKE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] dataBus = '0;
  logic       csN = 1'b1;
  logic       dacEn = 1'b0;
  logic       pdSel = 1'b1;
  logic [9:0] code1, code2;
  logic       outEn1, outEn2, ready;
  logic [1:0] pwrMode;

  int errors = 0;
  int checks = 0;
  logic [9:0] exp1 = '0;
  logic [9:0] exp2 = '0;

  always #2 clk = ~clk;

  apdac_frontend #(.DATA_W(10), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst(rst), .dataBus(dataBus), .csN(csN), .dacEn(dacEn),
    .pdSel(pdSel), .code1(code1), .code2(code2), .outEn1(outEn1),
    .outEn2(outEn2), .pwrMode(pwrMode), .ready(ready)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // a at next rising edge, b at the falling edge after it
  task automatic sendPair(input logic [9:0] a, input logic [9:0] b, input logic cs);
    @(negedge clk); #1 dataBus = a; csN = cs;
    @(posedge clk); #1 dataBus = b;
  endtask

  task automatic checkCodes(input string req);
    chk(req, "code1", code1, exp1);
    chk(req, "code2", code2, exp2);
  endtask

  task automatic testReset();
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "code1", code1, 0);
    chk("R1", "code2", code2, 0);
    chk("R1", "mode", pwrMode, 2'b00);
    chk("R1", "outEn1", outEn1, 0);
    chk("R1", "outEn2", outEn2, 0);
    chk("R1", "ready", ready, 0);
    rst = 1'b0;
  endtask

  task automatic goActive();
    @(posedge clk); #1 pdSel = 1'b0; dacEn = 1'b1;
    @(posedge clk); #1;
    chk("R2", "mode active", pwrMode, 2'b10);
    chk("R8", "outEn1 active", outEn1, 1);
    chk("R8", "outEn2 active", outEn2, 1);
    chk("R9", "ready at entry", ready, 0);
    repeat (WAKE - 1) @(posedge clk);
    #1 chk("R9", "ready one edge early", ready, 0);
    @(posedge clk); #1 chk("R9", "ready on time", ready, 1);
    checkCodes("R7");
  endtask

  task automatic testLatency(input logic [9:0] a, input logic [9:0] b);
    sendPair(a, b, 1'b0);
    chk("R5", "code1 before shift", code1, exp1);
    @(negedge clk); #1 csN = 1'b1;
    chk("R4", "code2 before shift", code2, exp2);
    @(posedge clk); #1;
    chk("R3", "code1 after shift", code1, a);
    chk("R5", "code2 still at rising edge", code2, exp2);
    @(negedge clk); #1;
    chk("R4", "code2 after shift", code2, b);
    chk("R5", "code1 still at falling edge", code1, a);
    exp1 = a; exp2 = b;
    repeat (3) @(posedge clk);
    #1 checkCodes("R6");
  endtask

  task automatic testCsIgnore(input logic [9:0] a, input logic [9:0] b);
    sendPair(a, b, 1'b1);
    repeat (3) @(posedge clk);
    #1 checkCodes("R6");
  endtask

  task automatic testStandby();
    @(posedge clk); #1 dacEn = 1'b0;
    @(posedge clk); #1;
    chk("R2", "mode standby", pwrMode, 2'b01);
    chk("R8", "outEn1 standby", outEn1, 0);
    chk("R8", "outEn2 standby", outEn2, 0);
    chk("R9", "ready standby", ready, 0);
    sendPair(10'h0F0, 10'h30F, 1'b0);
    @(negedge clk); #1 csN = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkCodes("R7");
    goActive();
  endtask

  task automatic testShutdown();
    @(posedge clk); #1 pdSel = 1'b1; dacEn = 1'b1;
    @(posedge clk); #1;
    chk("R2", "shutdown with enable high", pwrMode, 2'b00);
    chk("R8", "outEn1 shutdown", outEn1, 0);
    chk("R9", "ready shutdown", ready, 0);
    #1 dacEn = 1'b0;
    @(posedge clk); #1;
    chk("R2", "shutdown with enable low", pwrMode, 2'b00);
    chk("R8", "outEn2 shutdown", outEn2, 0);
    sendPair(10'h3C3, 10'h01E, 1'b0);
    @(negedge clk); #1 csN = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkCodes("R7");
    goActive();
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    goActive();
    testLatency(10'h3FF, 10'h000);
    testLatency(10'h155, 10'h2AA);
    testLatency(10'h001, 10'h200);
    for (int i = 0; i < 4; i++) begin
      testLatency(10'((i * 97 + 5) & 10'h3FF), 10'((i * 211 + 77) & 10'h3FF));
    end
    testCsIgnore(10'h0AA, 10'h355);
    testStandby();
    testLatency(10'h123, 10'h321);
    testShutdown();
    testLatency(10'h2F0, 10'h10F);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule